// File: doc/BRIEF.md
# Vector Length Control Register

This block holds the active vector length of a vector unit and computes new lengths for strip-mined loops. A caller presents a requested application length (an unsigned XLEN-bit count of remaining elements) together with a request strobe. The block compares the request with the current maximum vector length (MVL) supplied by the configuration logic. It writes the chosen length into the register and returns the same value on a registered response port one cycle later. When the request lies strictly between MVL and twice MVL, the block picks half the request so that the last two passes of a loop have nearly equal lengths.

The register can also be written directly through a write-any-read-legal control path, where values above MVL are clamped to MVL. A one-cycle reconfigure pulse from the configuration logic reinitialises the length to the new MVL. Changes that touch only element type never drive that pulse, so they leave the length alone. From the held length and MVL the block derives two per-element masks for a downstream datapath: elements that take part in an operation, and tail elements that the datapath zeroes in the destination.

Top module: `vl_ctrl`

## Requirements
- R1: When a set-length request carries a request `avl_i` >= 2*MVL, the new length is MVL.
- R2: When MVL < `avl_i` < 2*MVL, the new length is floor(`avl_i`/2).
- R3: When `avl_i` <= MVL, the new length is `avl_i`. `avl_i` is compared as a full unsigned XLEN-bit value, and doubling MVL never overflows, so `avl_i` = all ones gives MVL.
- R4: One cycle after a set-length request, `rsp_valid_o` is 1 for exactly one cycle and `rsp_len_o` equals the new `vl_o`, zero-extended to XLEN bits.
- R5: A direct write stores `csr_wdata_i` when it is <= MVL as an unsigned XLEN-bit value, and stores MVL otherwise.
- R6: A reconfigure pulse sets the length to `mvl_i` on the next cycle. It takes precedence over a set-length request or a direct write in the same cycle, and such a request then produces no response.
- R7: With no operation the length holds. A set-length request wins over a direct write in the same cycle.
- R8: `active_o[i]` is 1 exactly when i < `vl_o`.
- R9: `tail_o[i]` is 1 exactly when `vl_o` != 0 and `vl_o` <= i < MVL. When the length is 0, no bit of either mask is set.
- R10: After reset, `vl_o` is 0, `rsp_valid_o` is 0, and both masks are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mvl_i | input | LEN_W | Current maximum vector length, at most NELEM |
| cfg_wr_i | input | 1 | Reconfigure pulse, reinitialises the length to MVL |
| setvl_req_i | input | 1 | Set-length request strobe |
| avl_i | input | XLEN | Requested application length |
| csr_wr_i | input | 1 | Direct write strobe |
| csr_wdata_i | input | XLEN | Direct write data |
| vl_o | output | LEN_W | Active vector length |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rsp_len_o | output | XLEN | Length returned to the caller |
| active_o | output | NELEM | Per-element active mask |
| tail_o | output | NELEM | Per-element tail mask |

## Verification
On every cycle the assertions check the bounds and ordering rules: the length never exceeds the MVL seen when it was written, reconfigure always lands on MVL, idle cycles hold the length, the response mirrors the register, and the two masks never overlap and are empty at length zero. Only the bench's scenarios can show the exact arithmetic: which branch of the length rule a request takes, the floor of odd halved requests, the all-ones request, clamping of large direct writes, and the per-bit mask layout against a model.

// File: rtl/vl_pkg.sv
package vl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_RECFG = 2'd1,
        OP_SETVL = 2'd2,
        OP_WRITE = 2'd3
    } vl_op_e;

endpackage

// File: rtl/vl_len_calc.sv
module vl_len_calc #(
    parameter int XLEN  = 32,
    parameter int LEN_W = 6
) (
    input  logic [XLEN-1:0]  avl_i,
    input  logic [LEN_W-1:0] mvl_i,
    output logic [LEN_W-1:0] len_o
);
    // One extra bit so that 2*MVL and the request compare without overflow
    logic [XLEN:0] avl_x;
    logic [XLEN:0] mvl_x;
    logic [XLEN:0] twice_x;
    logic [XLEN-1:0] half;

    always_comb begin
        avl_x   = {1'b0, avl_i};
        mvl_x   = {{(XLEN + 1 - LEN_W){1'b0}}, mvl_i};
        twice_x = {{(XLEN - LEN_W){1'b0}}, mvl_i, 1'b0};
        half    = avl_i >> 1;
        if (avl_x >= twice_x) begin
            len_o = mvl_i;
        end else if (avl_x > mvl_x) begin
            // below 2*MVL, so half is below MVL and fits LEN_W bits
            len_o = half[LEN_W-1:0];
        end else begin
            len_o = avl_i[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/vl_warl_clamp.sv
module vl_warl_clamp #(
    parameter int XLEN  = 32,
    parameter int LEN_W = 6
) (
    input  logic [XLEN-1:0]  wdata_i,
    input  logic [LEN_W-1:0] mvl_i,
    output logic [LEN_W-1:0] len_o
);
    logic [XLEN-1:0] mvl_x;

    always_comb begin
        mvl_x = {{(XLEN - LEN_W){1'b0}}, mvl_i};
        len_o = (wdata_i > mvl_x) ? mvl_i : wdata_i[LEN_W-1:0];
    end
endmodule

// File: rtl/vl_elem_mask.sv
module vl_elem_mask #(
    parameter int NELEM = 32,
    parameter int LEN_W = 6
) (
    input  logic [LEN_W-1:0] vl_i,
    input  logic [LEN_W-1:0] mvl_i,
    output logic [NELEM-1:0] active_o,
    output logic [NELEM-1:0] tail_o
);
    logic vl_nz;
    assign vl_nz = (vl_i != '0);

    for (genvar i = 0; i < NELEM; i++) begin : g_elem
        localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
        assign active_o[i] = (IDX < vl_i);
        assign tail_o[i]   = vl_nz && (IDX >= vl_i) && (IDX < mvl_i);
    end
endmodule

// File: rtl/vl_ctrl.sv
module vl_ctrl #(
    parameter int XLEN  = 32,
    parameter int NELEM = 32,
    localparam int LEN_W = $clog2(NELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] mvl_i,
    input  logic             cfg_wr_i,
    input  logic             setvl_req_i,
    input  logic [XLEN-1:0]  avl_i,
    input  logic             csr_wr_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    output logic [LEN_W-1:0] vl_o,
    output logic             rsp_valid_o,
    output logic [XLEN-1:0]  rsp_len_o,
    output logic [NELEM-1:0] active_o,
    output logic [NELEM-1:0] tail_o
);
    import vl_pkg::*;

    typedef struct packed {
        logic [LEN_W-1:0] vl;
        logic             rsp_valid;
        logic [XLEN-1:0]  rsp_len;
    } vl_state_t;

    vl_state_t st_d, st_q;
    vl_op_e    op;
    logic [LEN_W-1:0] setvl_len;
    logic [LEN_W-1:0] write_len;

    vl_len_calc #(.XLEN(XLEN), .LEN_W(LEN_W)) u_calc (
        .avl_i (avl_i),
        .mvl_i (mvl_i),
        .len_o (setvl_len)
    );

    vl_warl_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
        .wdata_i (csr_wdata_i),
        .mvl_i   (mvl_i),
        .len_o   (write_len)
    );

    // Priority: reconfigure, then set-length, then direct write
    always_comb begin
        if (cfg_wr_i)         op = OP_RECFG;
        else if (setvl_req_i) op = OP_SETVL;
        else if (csr_wr_i)    op = OP_WRITE;
        else                  op = OP_IDLE;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        unique case (op)
            OP_RECFG: st_d.vl = mvl_i;
            OP_SETVL: begin
                st_d.vl        = setvl_len;
                st_d.rsp_valid = 1'b1;
                st_d.rsp_len   = {{(XLEN - LEN_W){1'b0}}, setvl_len};
            end
            OP_WRITE: st_d.vl = write_len;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    vl_elem_mask #(.NELEM(NELEM), .LEN_W(LEN_W)) u_mask (
        .vl_i     (st_q.vl),
        .mvl_i    (mvl_i),
        .active_o (active_o),
        .tail_o   (tail_o)
    );

    assign vl_o        = st_q.vl;
    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_len_o   = st_q.rsp_len;

    p_setvl_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_req_i && !cfg_wr_i) |=> (vl_o <= $past(mvl_i)));

    p_rsp_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_len_o == {{(XLEN - LEN_W){1'b0}}, vl_o}));

    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_req_i && !cfg_wr_i) |=> rsp_valid_o);

    p_warl_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_i && !cfg_wr_i && !setvl_req_i) |=> (vl_o <= $past(mvl_i)));

    p_recfg_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> (vl_o == $past(mvl_i) && !rsp_valid_o));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_i && !setvl_req_i && !csr_wr_i) |=> ($stable(vl_o) && !rsp_valid_o));

    p_active_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(active_o) == 32'(vl_o)));

    p_mask_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((active_o & tail_o) == '0));

    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_o == '0) |-> (active_o == '0 && tail_o == '0));
endmodule

// File: tb/vl_ctrl_tb.sv
module vl_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 32;
    localparam int NELEM = 32;
    localparam int LEN_W = $clog2(NELEM + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] mvl_i = '0;
    logic             cfg_wr_i = 1'b0;
    logic             setvl_req_i = 1'b0;
    logic [XLEN-1:0]  avl_i = '0;
    logic             csr_wr_i = 1'b0;
    logic [XLEN-1:0]  csr_wdata_i = '0;
    logic [LEN_W-1:0] vl_o;
    logic             rsp_valid_o;
    logic [XLEN-1:0]  rsp_len_o;
    logic [NELEM-1:0] active_o;
    logic [NELEM-1:0] tail_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    int mvl_m = 0;
    int vl_m  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vl_ctrl #(.XLEN(XLEN), .NELEM(NELEM)) u_dut (
        .clk(clk), .rst_n(rst_n), .mvl_i(mvl_i), .cfg_wr_i(cfg_wr_i),
        .setvl_req_i(setvl_req_i), .avl_i(avl_i), .csr_wr_i(csr_wr_i),
        .csr_wdata_i(csr_wdata_i), .vl_o(vl_o), .rsp_valid_o(rsp_valid_o),
        .rsp_len_o(rsp_len_o), .active_o(active_o), .tail_o(tail_o)
    );

    function automatic int exp_setvl(logic [XLEN-1:0] avl, int mvl);
        longint a = longint'(avl);
        if (a >= 2 * longint'(mvl)) return mvl;
        if (a > longint'(mvl))      return int'(a / 2);
        return int'(a);
    endfunction

    function automatic int exp_write(logic [XLEN-1:0] wd, int mvl);
        if (longint'(wd) > longint'(mvl)) return mvl;
        return int'(wd);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_masks();
        logic [NELEM-1:0] ea = '0;
        logic [NELEM-1:0] et = '0;
        for (int i = 0; i < NELEM; i++) begin
            ea[i] = (i < vl_m);
            et[i] = (vl_m != 0) && (i >= vl_m) && (i < mvl_m);
        end
        check("R8 active mask", longint'(active_o), longint'(ea));
        check("R9 tail mask", longint'(tail_o), longint'(et));
    endtask

    // Drive one cycle of strobes at a falling edge, check at the next one.
    task automatic step(bit cfg, int new_mvl, bit sv, logic [XLEN-1:0] avl,
                        bit wr, logic [XLEN-1:0] wd, string tag);
        bit exp_rsp;
        @(negedge clk);
        cfg_wr_i = cfg; setvl_req_i = sv; avl_i = avl;
        csr_wr_i = wr; csr_wdata_i = wd;
        if (cfg) mvl_i = LEN_W'(new_mvl);
        exp_rsp = 0;
        if (cfg) begin
            mvl_m = new_mvl; vl_m = new_mvl;
        end else if (sv) begin
            vl_m = exp_setvl(avl, mvl_m); exp_rsp = 1;
        end else if (wr) begin
            vl_m = exp_write(wd, mvl_m);
        end
        @(negedge clk);
        cfg_wr_i = 0; setvl_req_i = 0; csr_wr_i = 0;
        check(tag, longint'(vl_o), longint'(vl_m));
        check("R4 rsp valid", longint'(rsp_valid_o), longint'(exp_rsp));
        if (exp_rsp) check("R4 rsp length", longint'(rsp_len_o), longint'(vl_m));
        check_masks();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset length", longint'(vl_o), 0);
        check("R10 reset rsp valid", longint'(rsp_valid_o), 0);
        check("R10 reset masks", longint'(active_o | tail_o), 0);
        rst_n = 1'b1;

        step(1, 16, 0, 0, 0, 0, "R6 reconfigure");
        step(0, 0, 1, 40, 0, 0, "R1 avl above 2mvl");
        step(0, 0, 1, 32, 0, 0, "R1 avl equal 2mvl");
        step(0, 0, 1, 31, 0, 0, "R2 avl 2mvl-1");
        step(0, 0, 1, 17, 0, 0, "R2 avl mvl+1");
        step(0, 0, 1, 16, 0, 0, "R3 avl equal mvl");
        step(0, 0, 1, 5, 0, 0, "R3 avl small");
        step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R3 all-ones avl no overflow");
        step(0, 0, 1, 0, 0, 0, "R9 zero length");
        step(0, 0, 0, 0, 0, 0, "R7 hold idle");
        step(0, 0, 0, 0, 1, 7, "R5 write in range");
        step(0, 0, 0, 0, 1, 32'h8000_0010, "R5 write large clamps");
        step(0, 0, 0, 0, 1, 17, "R5 write mvl+1 clamps");
        step(0, 0, 1, 3, 1, 9, "R7 setvl wins over write");
        step(1, 32, 1, 2, 1, 1, "R6 reconfigure wins");
        step(0, 0, 1, 63, 0, 0, "R2 max mvl odd request");
        step(1, 4, 0, 0, 0, 0, "R6 reconfigure min");
        step(0, 0, 1, 7, 0, 0, "R2 small mvl");

        for (int k = 0; k < 400; k++) begin
            int sel = int'($urandom_range(0, 9));
            int base = int'($urandom_range(0, 3));
            logic [XLEN-1:0] v;
            if (base == 0)      v = XLEN'($urandom_range(0, 2 * mvl_m + 2));
            else if (base == 1) v = XLEN'(mvl_m + 1);
            else if (base == 2) v = XLEN'(2 * mvl_m - 1);
            else                v = $urandom;
            if (sel == 0)      step(1, int'($urandom_range(4, NELEM)), 0, 0, 0, 0, "R6 random reconfigure");
            else if (sel < 7)  step(0, 0, 1, v, 0, 0, "R1 R2 R3 random setvl");
            else if (sel < 9)  step(0, 0, 0, 0, 1, v, "R5 random write");
            else               step(0, 0, 0, 0, 0, 0, "R7 random idle");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule